// File: doc/BRIEF.md
# Support-Change Packet Framer

This block watches a 12-channel selection mask, the support set, and reacts only when it moves. When the mask differs from the copy held in a reference register, the block raises a single-clock `initiate` strobe for an external engine that recomputes the support. The same clock edge loads the new mask into the reference, so each change produces one strobe.

When the engine reports completion on `recomp_done`, the block sends the current support set as a burst on a valid-qualified word bus. The first word of the burst is the number of selected channels. Each word after it is the index of one selected channel, sent from the lowest index to the highest. An empty set produces no burst.

A matching receiver sits in the same block on its own pins. It rebuilds the count and the channel mask from a burst. When the burst ends it reports completion, and it flags an error if the number of index words does not match the count word. The receiver can be wired to the transmitter or driven from elsewhere.

Top module: `sup_pkt_top`

## Requirements
- R1: One clock after an edge where `sup_mask` differs from the stored reference, `initiate` is 1. The reference takes the new mask at that same edge, so `initiate` lasts exactly one clock when the mask then holds still.
- R2: While `sup_mask` holds its value, `initiate` stays 0.
- R3: `recomp_done` is accepted only when a change has been seen since the last accepted completion. At any other time it has no effect, and `pkt_valid` stays 0.
- R4: If the reference set is empty when a completion is accepted, no burst is sent and `pkt_valid` stays 0.
- R5: The clock after an accepted completion edge, `pkt_valid` is 1 and `pkt_data` carries the number of set bits, zero-extended. `pkt_valid` then stays 1 for exactly that many further cycles and returns to 0 after the last index word.
- R6: The index words are the positions of the set bits, from lowest to highest, with position 0 meaning channel 0, zero-extended to the bus width.
- R7: A completion that arrives while a burst is being sent is ignored. A mask change during a burst arms the block again, and the next completion after the burst sends the new set.
- R8: The receiver samples `rx_data` only while `rx_valid` is 1. The first word of a burst is taken as the count, and each later word below 12 sets that bit of the rebuilt mask. One clock after `rx_valid` falls, `rx_done` pulses for one cycle, and `rx_count` and `rx_set` hold the burst's count and mask until the next burst ends.
- R9: `rx_err` pulses together with `rx_done` when the number of index words received differs from the count word. It is 0 otherwise.
- R10: After reset, `initiate`, `pkt_valid`, `rx_done` and `rx_err` are 0, and `rx_count` and `rx_set` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_mask | input | 12 | Current support set, one bit per channel |
| recomp_done | input | 1 | Recomputation finished strobe |
| initiate | output | 1 | One-clock request to recompute the support |
| pkt_valid | output | 1 | Burst word qualifier |
| pkt_data | output | 8 | Count word, then channel indices |
| rx_valid | input | 1 | Receiver word qualifier |
| rx_data | input | 8 | Receiver word |
| rx_done | output | 1 | Burst completed pulse |
| rx_err | output | 1 | Word count mismatch pulse |
| rx_count | output | 8 | Count word of the last burst |
| rx_set | output | 12 | Mask rebuilt from the last burst |

## Verification
A stale or corrupted reference register shows up as a missing or extra `initiate` one clock after the mask moves, or after it fails to move. A wrong arming flag shows up as a burst that starts, or fails to start, on the clock after a completion strobe. An error in the work mask or in the lowest-bit selection gives an index word that is out of order, missing or repeated. That error either reaches the bus within the burst itself, or shows up as a mismatch in `rx_set` or `rx_count` one clock after `pkt_valid` falls. A receiver counter that is off by one raises `rx_err` on a burst that is well formed.

// File: rtl/sup_pkt_pkg.sv
package sup_pkt_pkg;

   typedef enum logic [0:0] {
      FR_IDLE = 1'b0,
      FR_SEND = 1'b1
   } fr_state_e;

endpackage

// File: rtl/sup_chg_det.sv
module sup_chg_det #(
   parameter int N_CH = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] mask_i,
   output logic [N_CH-1:0] ref_o,
   output logic            chg_o,
   output logic            init_o
);

   logic [N_CH-1:0] ref_q;
   logic            init_q;

   assign chg_o  = (mask_i != ref_q);
   assign ref_o  = ref_q;
   assign init_o = init_q;

   // reference follows the mask; pulse is the registered difference flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         init_q <= 1'b0;
      end else begin
         ref_q  <= mask_i;
         init_q <= chg_o;
      end
   end

endmodule

// File: rtl/sup_framer.sv
module sup_framer
   import sup_pkt_pkg::*;
#(
   parameter int N_CH = 12,
   parameter int DW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            chg_i,
   input  logic [N_CH-1:0] ref_i,
   input  logic            done_i,
   output logic            valid_o,
   output logic [DW-1:0]   data_o
);

   localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1;
   localparam int CW = $clog2(N_CH + 1);

   fr_state_e       state_q;
   logic            armed_q;
   logic [N_CH-1:0] work_q;
   logic [N_CH-1:0] low_1h;
   logic [IW-1:0]   low_idx;
   logic [CW-1:0]   ref_pop;
   logic            accept;
   logic            valid_q;
   logic [DW-1:0]   data_q;

   // lowest set bit of the remaining work mask
   for (genvar g = 0; g < N_CH; g++) begin : g_low
      if (g == 0) begin : g_first
         assign low_1h[g] = work_q[g];
      end else begin : g_rest
         assign low_1h[g] = work_q[g] & ~(|work_q[g-1:0]);
      end
   end

   always_comb begin
      low_idx = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (low_1h[i]) low_idx = low_idx | IW'(i);
      end
   end

   always_comb begin
      ref_pop = '0;
      for (int i = 0; i < N_CH; i++) begin
         ref_pop = ref_pop + CW'(ref_i[i]);
      end
   end

   assign accept  = done_i && armed_q && (state_q == FR_IDLE);
   assign valid_o = valid_q;
   assign data_o  = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else begin
         armed_q <= chg_i | (armed_q & ~accept);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FR_IDLE;
         work_q  <= '0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         case (state_q)
            FR_IDLE: begin
               if (accept && (ref_i != '0)) begin
                  state_q <= FR_SEND;
                  work_q  <= ref_i;
                  valid_q <= 1'b1;
                  data_q  <= DW'(ref_pop);
               end else begin
                  valid_q <= 1'b0;
               end
            end
            FR_SEND: begin
               if (work_q != '0) begin
                  work_q  <= work_q & ~low_1h;
                  valid_q <= 1'b1;
                  data_q  <= DW'(low_idx);
               end else begin
                  state_q <= FR_IDLE;
                  valid_q <= 1'b0;
               end
            end
            default: begin
               state_q <= FR_IDLE;
               valid_q <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/sup_rx.sv
module sup_rx #(
   parameter int N_CH = 12,
   parameter int DW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid_i,
   input  logic [DW-1:0]   data_i,
   output logic            done_o,
   output logic            err_o,
   output logic [DW-1:0]   count_o,
   output logic [N_CH-1:0] set_o
);

   localparam logic [DW-1:0] N_LIM = DW'(N_CH);

   logic            vd_q;
   logic [DW-1:0]   cnt_q;
   logic [DW-1:0]   got_q;
   logic [N_CH-1:0] acc_q;
   logic            done_q;
   logic            err_q;
   logic [DW-1:0]   count_q;
   logic [N_CH-1:0] set_q;
   logic            first_w;
   logic            end_w;

   assign first_w = valid_i && !vd_q;
   assign end_w   = !valid_i && vd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vd_q  <= 1'b0;
         cnt_q <= '0;
         got_q <= '0;
         acc_q <= '0;
      end else begin
         vd_q <= valid_i;
         if (first_w) begin
            cnt_q <= data_i;
            got_q <= '0;
            acc_q <= '0;
         end else if (valid_i) begin
            got_q <= got_q + 1'b1;
            if (data_i < N_LIM) acc_q <= acc_q | (N_CH'(1) << data_i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         count_q <= '0;
         set_q   <= '0;
      end else begin
         done_q <= end_w;
         err_q  <= end_w && (got_q != cnt_q);
         if (end_w) begin
            count_q <= cnt_q;
            set_q   <= acc_q;
         end
      end
   end

   assign done_o  = done_q;
   assign err_o   = err_q;
   assign count_o = count_q;
   assign set_o   = set_q;

endmodule

// File: rtl/sup_pkt_top.sv
module sup_pkt_top #(
   parameter int N_CH = 12,
   parameter int DW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] sup_mask,
   input  logic            recomp_done,
   output logic            initiate,
   output logic            pkt_valid,
   output logic [DW-1:0]   pkt_data,
   input  logic            rx_valid,
   input  logic [DW-1:0]   rx_data,
   output logic            rx_done,
   output logic            rx_err,
   output logic [DW-1:0]   rx_count,
   output logic [N_CH-1:0] rx_set
);

   localparam int CW = $clog2(N_CH + 1);

   if (N_CH < 2) begin : g_bad_nch
      $error("sup_pkt_top: N_CH must be at least 2");
   end
   if (DW < CW) begin : g_bad_dw
      $error("sup_pkt_top: DW too narrow for count and index words");
   end

   logic [N_CH-1:0] ref_w;
   logic            chg_w;

   sup_chg_det #(.N_CH(N_CH)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask_i (sup_mask),
      .ref_o  (ref_w),
      .chg_o  (chg_w),
      .init_o (initiate)
   );

   sup_framer #(.N_CH(N_CH), .DW(DW)) u_fr (
      .clk     (clk),
      .rst_n   (rst_n),
      .chg_i   (chg_w),
      .ref_i   (ref_w),
      .done_i  (recomp_done),
      .valid_o (pkt_valid),
      .data_o  (pkt_data)
   );

   sup_rx #(.N_CH(N_CH), .DW(DW)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (rx_valid),
      .data_i  (rx_data),
      .done_o  (rx_done),
      .err_o   (rx_err),
      .count_o (rx_count),
      .set_o   (rx_set)
   );

endmodule

// File: rtl/sup_pkt_chk.sv
module sup_pkt_chk #(
   parameter int N_CH = 12,
   parameter int DW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] sup_mask,
   input logic            recomp_done,
   input logic            initiate,
   input logic            pkt_valid,
   input logic [DW-1:0]   pkt_data,
   input logic            rx_done,
   input logic            rx_err
);

   logic live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   // R1: a mask change yields the pulse on the next clock
   a_r1_change_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && (sup_mask != $past(sup_mask))) |=> initiate);

   // R2: a held mask ends the pulse after one clock
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && initiate && $stable(sup_mask)) |=> !initiate);

   // R3: a burst begins only after a completion strobe
   a_r3_burst_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_valid) |-> $past(recomp_done));

   // R4 / R5: the count word of a burst is never zero
   a_r5_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_valid) |-> (pkt_data != '0));

   // R6: index words rise strictly within a burst
   a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && pkt_valid && $past(pkt_valid) && $past(pkt_valid, 2))
         |-> (pkt_data > $past(pkt_data)));

   // R6: index words stay inside the channel range
   a_r6_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && pkt_valid && $past(pkt_valid)) |-> (pkt_data < DW'(N_CH)));

   // R8: completion is a single-clock pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R9: error only alongside completion
   a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> rx_done);

endmodule

bind sup_pkt_top sup_pkt_chk #(.N_CH(N_CH), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sup_mask    (sup_mask),
   .recomp_done (recomp_done),
   .initiate    (initiate),
   .pkt_valid   (pkt_valid),
   .pkt_data    (pkt_data),
   .rx_done     (rx_done),
   .rx_err      (rx_err)
);

// File: tb/sup_pkt_top_tb.sv
`timescale 1ns/1ps
module sup_pkt_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N_CH       = 12;
   localparam int DW         = 8;
   localparam int WATCHDOG   = 100000;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [N_CH-1:0] sup_mask;
   logic            recomp_done;
   logic            initiate;
   logic            pkt_valid;
   logic [DW-1:0]   pkt_data;
   logic            rx_valid;
   logic [DW-1:0]   rx_data;
   logic            rx_done;
   logic            rx_err;
   logic [DW-1:0]   rx_count;
   logic [N_CH-1:0] rx_set;

   logic            loop_en;
   logic            drv_valid;
   logic [DW-1:0]   drv_data;

   int checks = 0;
   int errors = 0;
   logic [N_CH-1:0] cur_ref;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rx_valid = loop_en ? pkt_valid : drv_valid;
   assign rx_data  = loop_en ? pkt_data  : drv_data;

   sup_pkt_top #(.N_CH(N_CH), .DW(DW)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sup_mask    (sup_mask),
      .recomp_done (recomp_done),
      .initiate    (initiate),
      .pkt_valid   (pkt_valid),
      .pkt_data    (pkt_data),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .rx_done     (rx_done),
      .rx_err      (rx_err),
      .rx_count    (rx_count),
      .rx_set      (rx_set)
   );

   function automatic int f_pop(input logic [N_CH-1:0] m);
      int n = 0;
      for (int i = 0; i < N_CH; i++) n += int'(m[i]);
      return n;
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called just after the edge that accepted a completion for set m
   task automatic expect_packet(input logic [N_CH-1:0] m, input bit inject,
                                input logic [N_CH-1:0] inj_mask);
      int n = f_pop(m);
      bit first = 1'b1;
      chk_eq("R5 count-word valid", int'(pkt_valid), 1);
      chk_eq("R5 count word", int'(pkt_data), n);
      if (inject) begin
         sup_mask    = inj_mask;
         recomp_done = 1'b1;
      end
      for (int i = 0; i < N_CH; i++) begin
         if (m[i]) begin
            step();
            if (first) begin
               recomp_done = 1'b0;
               first = 1'b0;
            end
            chk_eq("R6 index valid", int'(pkt_valid), 1);
            chk_eq("R6 index word", int'(pkt_data), i);
         end
      end
      step();
      chk_eq("R5 valid falls", int'(pkt_valid), 0);
      step();
      chk_eq("R8 rx_done", int'(rx_done), 1);
      chk_eq("R8 rx_count", int'(rx_count), n);
      chk_eq("R8 rx_set", int'(rx_set), int'(m));
      chk_eq("R9 no error on good burst", int'(rx_err), 0);
   endtask

   task automatic do_change(input logic [N_CH-1:0] m);
      sup_mask = m;
      step();
      chk_eq("R1 initiate raised", int'(initiate), 1);
      recomp_done = 1'b1;
      step();
      recomp_done = 1'b0;
      chk_eq("R1 initiate one clock", int'(initiate), 0);
      cur_ref = m;
      if (m == '0) begin
         for (int k = 0; k < 3; k++) begin
            chk_eq("R4 empty set no burst", int'(pkt_valid), 0);
            step();
         end
      end else begin
         expect_packet(m, 1'b0, '0);
      end
   endtask

   task automatic hold_still(input int cycles);
      for (int k = 0; k < cycles; k++) begin
         step();
         chk_eq("R2 stable mask no initiate", int'(initiate), 0);
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [N_CH-1:0] m;
      int unused_seed;
      unused_seed = $urandom(32'h5EED_1234);
      rst_n       = 1'b0;
      sup_mask    = '0;
      recomp_done = 1'b0;
      loop_en     = 1'b1;
      drv_valid   = 1'b0;
      drv_data    = '0;
      cur_ref     = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R10 reset state
      chk_eq("R10 initiate", int'(initiate), 0);
      chk_eq("R10 pkt_valid", int'(pkt_valid), 0);
      chk_eq("R10 rx_done", int'(rx_done), 0);
      chk_eq("R10 rx_err", int'(rx_err), 0);
      chk_eq("R10 rx_count", int'(rx_count), 0);
      chk_eq("R10 rx_set", int'(rx_set), 0);

      // R3: completion with nothing pending
      recomp_done = 1'b1;
      step();
      recomp_done = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk_eq("R3 stray done ignored", int'(pkt_valid), 0);
         step();
      end

      // directed corners: single low bit, single high bit, full set
      do_change(12'h001);
      hold_still(3);
      do_change(12'h800);
      do_change(12'hFFF);
      // R3 again right after a completed burst
      recomp_done = 1'b1;
      step();
      recomp_done = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk_eq("R3 done after burst ignored", int'(pkt_valid), 0);
         step();
      end
      // R4 empty set
      do_change(12'h000);

      // R7: change and completion during a burst
      sup_mask = 12'h0A5;
      step();
      chk_eq("R1 initiate raised", int'(initiate), 1);
      recomp_done = 1'b1;
      step();
      recomp_done = 1'b0;
      expect_packet(12'h0A5, 1'b1, 12'h300);
      recomp_done = 1'b1;
      step();
      recomp_done = 1'b0;
      chk_eq("R7 rearmed burst starts", int'(pkt_valid), 1);
      expect_packet(12'h300, 1'b0, '0);
      cur_ref = 12'h300;

      // constrained random masks
      for (int it = 0; it < 30; it++) begin
         int sel = int'($urandom % 6);
         if (sel == 0)      m = '0;
         else if (sel == 1) m = cur_ref;
         else               m = N_CH'($urandom);
         if (m == cur_ref) begin
            sup_mask = m;
            hold_still(2);
         end else begin
            do_change(m);
         end
      end

      // R8 / R9: receiver driven directly
      loop_en   = 1'b0;
      drv_valid = 1'b1;
      drv_data  = 8'd3;
      step();
      drv_data = 8'd2;
      step();
      drv_data = 8'd5;
      step();
      drv_valid = 1'b0;
      step();
      chk_eq("R9 short burst rx_done", int'(rx_done), 1);
      chk_eq("R9 short burst rx_err", int'(rx_err), 1);
      chk_eq("R8 short burst rx_count", int'(rx_count), 3);
      chk_eq("R8 short burst rx_set", int'(rx_set), 12'h024);
      step();
      chk_eq("R8 rx_done one clock", int'(rx_done), 0);
      chk_eq("R9 rx_err one clock", int'(rx_err), 0);

      drv_valid = 1'b1;
      drv_data  = 8'd1;
      step();
      drv_data = 8'd7;
      step();
      drv_data = 8'd9;
      step();
      drv_valid = 1'b0;
      step();
      chk_eq("R9 long burst rx_err", int'(rx_err), 1);
      chk_eq("R8 long burst rx_set", int'(rx_set), 12'h280);

      drv_valid = 1'b1;
      drv_data  = 8'd1;
      step();
      drv_data = 8'd7;
      step();
      drv_valid = 1'b0;
      drv_data  = 8'd3;
      step();
      chk_eq("R8 data ignored without valid", int'(rx_set), 12'h080);
      chk_eq("R9 matched burst no error", int'(rx_err), 0);
      chk_eq("R8 matched rx_count", int'(rx_count), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule